// File: doc/BRIEF.md
# UART Register Bank

This block is the software-visible register file of a small serial port. It decodes single-cycle 32-bit read and write requests at fixed word offsets and holds the control word, the baud divisor word and the FIFO threshold settings. Bits from the control word drive the receive, transmit and baud generator enables downstream. Two control bits act as one-shot FIFO flush commands that clear themselves.

Three sticky interrupt flags are gathered from the transmit and receive paths: transmit queue empty, receive overrun and receive data ready. Software clears all of them at once by writing zero to the interrupt register. The data register sits at its own offset. A write hands the low byte to the transmit queue. A read returns the head of the receive queue, with three error flags above the byte, and pops that entry in the same cycle.

Registers are stored in natural bit order. A parameter selects big-endian byte order on the bus, which swaps the four byte lanes of write and read data. The shift engine, the FIFOs and the bus protocol adapter lie outside the block.

Top module: `uart_regbank`

## Requirements
- R1: After reset every register and `irq` read as zero, and all strobes, enables and `bus_rvalid` are low.
- R2: The control register (offset 0x00) stores only bits 4:0, 14:8 and 23:16. Bit 5, bit 15 and bits 31:24 always read zero.
- R3: Writing control bit 6 raises `rxq_flush`, and writing bit 7 raises `txq_flush`, for exactly the one cycle after the write. Both bits then read back as zero.
- R4: `rx_enable`, `tx_enable` and `baud_enable` follow control bits 21, 22 and 23, and `ctrl_word` shows the stored control word.
- R5: The baud word (offset 0x04) stores and returns all 32 bits and drives `baud_word`.
- R6: The FIFO config register (offset 0x08) keeps the receive threshold in bits 11:8 and the transmit threshold in bits 15:12, driving `rx_thresh` and `tx_thresh`. All other bits read zero.
- R7: A high level on `txq_empty`, `rxq_overrun` or `rxq_ready` at a clock edge sets interrupt bit 5, 7 or 11 (offset 0x10). The bit stays set until it is cleared. `irq` is high while any of these bits is set.
- R8: A write of zero to offset 0x10 clears all three bits, and a nonzero write there changes nothing. An event in the same cycle as the clear leaves its own bit set.
- R9: A write to the data register (offset 0x14) pulses `tx_push` in the request cycle, with `tx_byte` equal to register bits 7:0.
- R10: A read of offset 0x14 while `rxq_ready` is high pulses `rx_pop` in the request cycle and returns `rxq_head` in bits 10:0: data in 7:0, frame error in 8, parity error in 9, break in 10. A read while `rxq_ready` is low returns zero and does not pop.
- R11: Every read returns data with `bus_rvalid` one cycle after the request. Unmapped offsets read zero, and writes to them change no register.
- R12: With `BIG_ENDIAN` = 1, register bits 7:0 travel on bus bits 31:24, bits 15:8 on 23:16, bits 23:16 on 15:8 and bits 31:24 on 7:0. With `BIG_ENDIAN` = 0, the bus carries register bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data in bus byte order |
| bus_rdata | output | 32 | Read data in bus byte order |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| ctrl_word | output | 32 | Stored control word |
| rx_enable | output | 1 | Receive enable |
| tx_enable | output | 1 | Transmit enable |
| baud_enable | output | 1 | Baud generator enable |
| rxq_flush | output | 1 | One-cycle receive FIFO flush |
| txq_flush | output | 1 | One-cycle transmit FIFO flush |
| baud_word | output | 32 | Baud divisor word |
| rx_thresh | output | 4 | Receive FIFO threshold |
| tx_thresh | output | 4 | Transmit FIFO threshold |
| tx_push | output | 1 | Push `tx_byte` into the transmit FIFO |
| tx_byte | output | 8 | Byte to transmit |
| rxq_ready | input | 1 | Receive FIFO holds at least one entry |
| rxq_head | input | 11 | Oldest receive entry with its error flags |
| rx_pop | output | 1 | Remove the receive FIFO head |
| txq_empty | input | 1 | Transmit FIFO empty |
| rxq_overrun | input | 1 | Receive overrun event |
| irq | output | 1 | Any interrupt flag set |

## Verification
The bench builds two instances side by side. `u0` uses the defaults, `ADDR_W` = 5 and `BIG_ENDIAN` = 1. `u1` sets `BIG_ENDIAN` = 0 and receives the same accesses, with write data left in natural order. Comparing the two makes a wrong byte lane visible, both on the read path and on the byte handed to the transmit queue. A 5-bit offset reaches 0x18, so the bench can probe unmapped offsets above the data register as well as the gap at 0x0C.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;
    localparam int REG_BYTES = 4;
    localparam int REG_W     = 8 * REG_BYTES;
    localparam int BYTE_W    = 8;
    localparam int RXE_W     = BYTE_W + 3;
    localparam int THR_W     = 4;
    localparam int NIRQ      = 3;

    localparam int OFS_CTRL  = 'h00;
    localparam int OFS_BAUD  = 'h04;
    localparam int OFS_FCFG  = 'h08;
    localparam int OFS_IRQ   = 'h10;
    localparam int OFS_DATA  = 'h14;

    localparam int CB_RXFLUSH = 6;
    localparam int CB_TXFLUSH = 7;
    localparam int CB_RXEN    = 21;
    localparam int CB_TXEN    = 22;
    localparam int CB_BAUDEN  = 23;

    localparam int IB_TXEMPTY = 5;
    localparam int IB_OVERRUN = 7;
    localparam int IB_RXREADY = 11;

    localparam int FC_RXTHR = 8;
    localparam int FC_TXTHR = 12;

    localparam logic [REG_W-1:0] CTRL_KEEP = 32'h00FF_7FDF;
    localparam logic [REG_W-1:0] FCFG_KEEP = 32'h0000_FF00;

    typedef struct packed {
        logic [REG_W-1:0] ctrl;
        logic [REG_W-1:0] baud;
        logic [REG_W-1:0] fcfg;
        logic [REG_W-1:0] rdata;
        logic             rvalid;
    } regs_t;
endpackage

// File: rtl/uart_bytelane.sv
module uart_bytelane #(
    parameter bit SWAP  = 1'b1,
    parameter int BYTES = 4
) (
    input  logic [8*BYTES-1:0] d_i,
    output logic [8*BYTES-1:0] d_o
);
    generate
        if (SWAP) begin : g_swap
            for (genvar b = 0; b < BYTES; b++) begin : g_lane
                assign d_o[8*b +: 8] = d_i[8*(BYTES-1-b) +: 8];
            end
        end else begin : g_pass
            assign d_o = d_i;
        end
    endgenerate
endmodule

// File: rtl/uart_irq_latch.sv
module uart_irq_latch #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         clr_i,
    output logic [N-1:0] flag_o
);
    logic [N-1:0] flag_d, flag_q;

    always_comb begin
        flag_d = clr_i ? '0 : flag_q;
        flag_d = flag_d | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;

    generate
        for (genvar i = 0; i < N; i++) begin : g_chk
            // R7: an event is remembered in its flag
            a_r7_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
                set_i[i] |=> flag_o[i]);
            // R7: a flag only drops through a clear
            a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
                (flag_o[i] && !clr_i) |=> flag_o[i]);
        end
    endgenerate

    // R8: a clear with no event empties every flag
    a_r8_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && set_i == '0) |=> (flag_o == '0));
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
    import uart_regbank_pkg::*;
#(
    parameter int ADDR_W     = 5,
    parameter bit BIG_ENDIAN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    output logic [31:0]       ctrl_word,
    output logic              rx_enable,
    output logic              tx_enable,
    output logic              baud_enable,
    output logic              rxq_flush,
    output logic              txq_flush,
    output logic [31:0]       baud_word,
    output logic [3:0]        rx_thresh,
    output logic [3:0]        tx_thresh,
    output logic              tx_push,
    output logic [7:0]        tx_byte,
    input  logic              rxq_ready,
    input  logic [10:0]       rxq_head,
    output logic              rx_pop,
    input  logic              txq_empty,
    input  logic              rxq_overrun,
    output logic              irq
);
    localparam int PAD_W = REG_W - RXE_W;

    regs_t             cur, nx;
    logic [REG_W-1:0]  wdata_n;
    logic [NIRQ-1:0]   irq_set, irq_flags;
    logic              irq_clr;
    logic              wr_en, rd_en;
    logic              hit_ctrl, hit_baud, hit_fcfg, hit_irq, hit_data;
    logic [REG_W-1:0]  irq_word;

    uart_bytelane #(.SWAP(BIG_ENDIAN), .BYTES(REG_BYTES)) u_win (
        .d_i (bus_wdata),
        .d_o (wdata_n)
    );

    assign wr_en    = bus_req &&  bus_we;
    assign rd_en    = bus_req && !bus_we;
    assign hit_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
    assign hit_baud = (bus_addr == ADDR_W'(OFS_BAUD));
    assign hit_fcfg = (bus_addr == ADDR_W'(OFS_FCFG));
    assign hit_irq  = (bus_addr == ADDR_W'(OFS_IRQ));
    assign hit_data = (bus_addr == ADDR_W'(OFS_DATA));

    assign irq_set = {rxq_ready, rxq_overrun, txq_empty};
    assign irq_clr = wr_en && hit_irq && (wdata_n == '0);

    uart_irq_latch #(.N(NIRQ)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (irq_set),
        .clr_i  (irq_clr),
        .flag_o (irq_flags)
    );

    always_comb begin
        irq_word             = '0;
        irq_word[IB_TXEMPTY] = irq_flags[0];
        irq_word[IB_OVERRUN] = irq_flags[1];
        irq_word[IB_RXREADY] = irq_flags[2];
    end

    always_comb begin
        nx                 = cur;
        nx.ctrl[CB_RXFLUSH] = 1'b0;
        nx.ctrl[CB_TXFLUSH] = 1'b0;
        nx.rvalid          = rd_en;
        nx.rdata           = '0;
        if (wr_en) begin
            if (hit_ctrl) nx.ctrl = wdata_n & CTRL_KEEP;
            if (hit_baud) nx.baud = wdata_n;
            if (hit_fcfg) nx.fcfg = wdata_n & FCFG_KEEP;
        end
        if (rd_en) begin
            if (hit_ctrl) nx.rdata = cur.ctrl;
            if (hit_baud) nx.rdata = cur.baud;
            if (hit_fcfg) nx.rdata = cur.fcfg;
            if (hit_irq)  nx.rdata = irq_word;
            if (hit_data && rxq_ready) nx.rdata = {{PAD_W{1'b0}}, rxq_head};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur <= '0;
        else        cur <= nx;
    end

    uart_bytelane #(.SWAP(BIG_ENDIAN), .BYTES(REG_BYTES)) u_rout (
        .d_i (cur.rdata),
        .d_o (bus_rdata)
    );

    assign bus_rvalid  = cur.rvalid;
    assign ctrl_word   = cur.ctrl;
    assign rx_enable   = cur.ctrl[CB_RXEN];
    assign tx_enable   = cur.ctrl[CB_TXEN];
    assign baud_enable = cur.ctrl[CB_BAUDEN];
    assign rxq_flush   = cur.ctrl[CB_RXFLUSH];
    assign txq_flush   = cur.ctrl[CB_TXFLUSH];
    assign baud_word   = cur.baud;
    assign rx_thresh   = cur.fcfg[FC_RXTHR +: THR_W];
    assign tx_thresh   = cur.fcfg[FC_TXTHR +: THR_W];
    assign tx_push     = wr_en && hit_data;
    assign tx_byte     = wdata_n[BYTE_W-1:0];
    assign rx_pop      = rd_en && hit_data && rxq_ready;
    assign irq         = |irq_flags;

    // R3: a flush request appears on the strobe in the next cycle
    a_r3_rx_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit_ctrl && wdata_n[CB_RXFLUSH]) |=> rxq_flush);
    a_r3_tx_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit_ctrl && wdata_n[CB_TXFLUSH]) |=> txq_flush);
    // R3: without a new request the strobe lasts one cycle
    a_r3_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
        (rxq_flush && !(wr_en && hit_ctrl)) |=> !rxq_flush);
    // R11: every read answers in the next cycle
    a_r11_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> bus_rvalid);
    a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |=> !bus_rvalid);
    // R10: a data read of an empty queue returns zero
    a_r10_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && hit_data && !rxq_ready) |=> (bus_rdata == '0));
    // R9/R10: push and pop never coincide
    a_r9_push_pop_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_push && rx_pop));
    // R2: reserved control bits never become set
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_word & ~CTRL_KEEP) == '0);
endmodule

// File: tb/sim_uart_regbank.sv
module sim_uart_regbank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] w0 = '0, w1 = '0;
    logic        rxq_ready = 1'b0, txq_empty = 1'b0, rxq_overrun = 1'b0;
    logic [10:0] rxq_head = '0;

    logic [31:0] r0, r1, ctrl0, ctrl1, baud0, baud1;
    logic        rv0, rv1, rxe0, rxe1, txe0, txe1, be0, be1, rf0, rf1, tf0, tf1;
    logic [3:0]  rth0, rth1, tth0, tth1;
    logic        push0, push1, pop0, pop1, irq0, irq1;
    logic [7:0]  tb0, tb1;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    uart_regbank #(.ADDR_W(5), .BIG_ENDIAN(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(w0), .bus_rdata(r0), .bus_rvalid(rv0), .ctrl_word(ctrl0),
        .rx_enable(rxe0), .tx_enable(txe0), .baud_enable(be0), .rxq_flush(rf0), .txq_flush(tf0),
        .baud_word(baud0), .rx_thresh(rth0), .tx_thresh(tth0), .tx_push(push0), .tx_byte(tb0),
        .rxq_ready(rxq_ready), .rxq_head(rxq_head), .rx_pop(pop0), .txq_empty(txq_empty),
        .rxq_overrun(rxq_overrun), .irq(irq0));

    uart_regbank #(.ADDR_W(5), .BIG_ENDIAN(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(w1), .bus_rdata(r1), .bus_rvalid(rv1), .ctrl_word(ctrl1),
        .rx_enable(rxe1), .tx_enable(txe1), .baud_enable(be1), .rxq_flush(rf1), .txq_flush(tf1),
        .baud_word(baud1), .rx_thresh(rth1), .tx_thresh(tth1), .tx_push(push1), .tx_byte(tb1),
        .rxq_ready(rxq_ready), .rxq_head(rxq_head), .rx_pop(pop1), .txq_empty(txq_empty),
        .rxq_overrun(rxq_overrun), .irq(irq1));

    function automatic logic [31:0] sw(input logic [31:0] x);
        return {x[7:0], x[15:8], x[23:16], x[31:24]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // write of register value v; ends one idle cycle later at a negedge
    task automatic wr(input logic [4:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; w0 = sw(v); w1 = v;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        @(negedge clk);
    endtask

    // read; returns register values from u0 (unswapped) and u1, plus pop seen
    task automatic rd(input logic [4:0] a, output logic [31:0] v0, output logic [31:0] v1,
                      output logic popped);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 popped = pop0;
        @(negedge clk);
        bus_req = 1'b0;
        v0 = sw(r0); v1 = r1;
        chk("R11 rvalid", {31'b0, rv0}, 32'h1);
    endtask

    localparam logic [68:0] VEC [0:7] = '{
        {5'h00, 32'hFFFF_FFFF, 32'h00FF_7F1F},
        {5'h00, 32'h0000_0000, 32'h0000_0000},
        {5'h04, 32'hA5C3_1E07, 32'hA5C3_1E07},
        {5'h08, 32'hFFFF_FFFF, 32'h0000_FF00},
        {5'h08, 32'h0000_4400, 32'h0000_4400},
        {5'h0C, 32'h1234_5678, 32'h0000_0000},
        {5'h18, 32'h1234_5678, 32'h0000_0000},
        {5'h10, 32'h0000_0003, 32'h0000_0000}
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v0, v1;
        logic p;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 ctrl_word", ctrl0, 0);
        chk("R1 outputs", {rxe0, txe0, be0, rf0, tf0, irq0, rv0, push0, pop0}, 0);
        chk("R1 baud/thr", {baud0[23:0], rth0, tth0}, 0);
        foreach (VEC[i]) begin
            rd(VEC[i][68:64], v0, v1, p);
            chk("R1 reset read", v0, 0);
        end

        // R2 R5 R6 R11: table of write/readback vectors
        foreach (VEC[i]) begin
            wr(VEC[i][68:64], VEC[i][63:32]);
            rd(VEC[i][68:64], v0, v1, p);
            chk($sformatf("R2/R5/R6/R11 vec %0d u0", i), v0, VEC[i][31:0]);
            chk($sformatf("R12 vec %0d u1", i), v1, VEC[i][31:0]);
        end
        chk("R11 unmapped writes ignored baud", baud0, 32'hA5C3_1E07);
        chk("R5 baud_word", baud0, 32'hA5C3_1E07);
        chk("R6 thresholds", {rth0, tth0}, {4'h4, 4'h4});
        wr(5'h08, 32'h0000_A300);
        chk("R6 thresholds A3", {tth0, rth0}, {4'hA, 4'h3});

        // R12: raw bus lanes
        wr(5'h04, 32'h1122_3344);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = 5'h04;
        @(negedge clk);
        bus_req = 1'b0;
        chk("R12 big-endian lanes", r0, 32'h4433_2211);
        chk("R12 natural lanes", r1, 32'h1122_3344);

        // R3: flush strobes
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 5'h00; w0 = sw(32'h40); w1 = 32'h40;
        #1 chk("R3 no early rx flush", {31'b0, rf0}, 0);
        @(negedge clk);
        bus_req = 1'b0;
        chk("R3 rx flush pulse", {30'b0, rf0, tf0}, 32'h2);
        @(negedge clk);
        chk("R3 rx flush ends", {30'b0, rf0, tf0}, 0);
        wr(5'h00, 32'h80);
        rd(5'h00, v0, v1, p);
        chk("R3 flush bits read zero", v0, 0);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 5'h00; w0 = sw(32'h80); w1 = 32'h80;
        @(negedge clk);
        bus_req = 1'b0;
        chk("R3 tx flush pulse", {30'b0, rf0, tf0}, 32'h1);
        @(negedge clk);
        chk("R3 tx flush ends", {31'b0, tf0}, 0);

        // R4: enables
        wr(5'h00, 32'h00E0_0000);
        chk("R4 all enables", {29'b0, rxe0, txe0, be0}, 32'h7);
        chk("R4 ctrl_word", ctrl0, 32'h00E0_0000);
        wr(5'h00, 32'h0020_0000);
        chk("R4 rx only", {29'b0, rxe0, txe0, be0}, 32'h4);
        wr(5'h00, 32'h0080_0000);
        chk("R4 baud only", {29'b0, rxe0, txe0, be0}, 32'h1);

        // R9: transmit push
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 5'h14; w0 = sw(32'h1234_56AB); w1 = 32'h1234_56AB;
        #1 chk("R9 push", {31'b0, push0}, 1);
        chk("R9 byte u0", {24'b0, tb0}, 32'hAB);
        chk("R12 byte u1", {24'b0, tb1}, 32'hAB);
        @(negedge clk);
        bus_req = 1'b0;
        #1 chk("R9 push ends", {31'b0, push0}, 0);

        // R10: receive pop
        rxq_ready = 1'b1; rxq_head = 11'h5A5;
        rd(5'h14, v0, v1, p);
        chk("R10 pop", {31'b0, p}, 1);
        chk("R10 head with flags", v0, 32'h0000_05A5);
        rxq_head = 11'h0FF;
        rd(5'h14, v0, v1, p);
        chk("R10 clean byte", v0, 32'h0000_00FF);
        rxq_ready = 1'b0;
        wr(5'h10, 0);
        rd(5'h14, v0, v1, p);
        chk("R10 empty no pop", {31'b0, p}, 0);
        chk("R10 empty reads zero", v0, 0);

        // R7 R8: interrupts
        rd(5'h10, v0, v1, p);
        chk("R8 cleared", v0, 0);
        chk("R8 irq low", {31'b0, irq0}, 0);
        @(negedge clk); txq_empty = 1'b1;
        @(negedge clk); txq_empty = 1'b0;
        rd(5'h10, v0, v1, p);
        chk("R7 tx empty latched", v0, 32'h20);
        chk("R7 irq", {31'b0, irq0}, 1);
        wr(5'h10, 32'h0000_0001);
        rd(5'h10, v0, v1, p);
        chk("R8 nonzero write ignored", v0, 32'h20);
        wr(5'h10, 0);
        rd(5'h10, v0, v1, p);
        chk("R8 zero write clears", v0, 0);
        @(negedge clk); rxq_overrun = 1'b1; rxq_ready = 1'b1;
        @(negedge clk); rxq_overrun = 1'b0; rxq_ready = 1'b0;
        rd(5'h10, v0, v1, p);
        chk("R7 overrun and ready", v0, 32'h880);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 5'h10; w0 = 0; w1 = 0; txq_empty = 1'b1;
        @(negedge clk);
        bus_req = 1'b0; txq_empty = 1'b0;
        rd(5'h10, v0, v1, p);
        chk("R8 set wins over clear", v0, 32'h20);
        chk("R12 irq u1", v1, 32'h20);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule